// File: doc/BRIEF.md
# Dual-Grain Coherence Directory Entry

This block holds one directory entry covering an aligned 1 KB region of sixteen 64-byte blocks in a sixteen-node system. Sharing is recorded at two granularities. Each block keeps a valid flag, a two-bit MESI-like state and a four-bit pointer to its single holder. The whole region keeps one sixteen-bit vector of the extra nodes that share some block in it without being that block's holder. The entry can also be owned privately by one node. In that case the node's later misses in the region bypass the directory.

A node presents a read, write or evict request. The entry answers with one probe beat. The beat carries a target node mask, a probe kind and a private-grant flag. The entry then stays busy until the requester returns an unblock message. For writes, that message carries the invalidated nodes' "still holds another block in this region" reports. These reports are used to clear stale region-vector bits. For revocation of a private region, the message carries the owner's held-block bitmap. Every state change takes effect when the unblock message is accepted.

Encodings: request op READ=0, WRITE=1, EVICT=2. Probe kind NONE=0, FWD=1, INV=2, RVK=3, MISS=4. Block state I=0, S=1, E=2, M=3. Node n and block b map to bit n and bit b of masks and bitmaps.

Top module: `dgd_entry`

## Requirements
- R1: After reset, req_ready is 1, probe_valid is 0 and the entry is empty, so the first read or write to any tag is treated as an allocation.
- R2: A read or write to an empty entry loads the tag and grants the whole region privately to the requester: probe kind NONE, mask 0, probe_grant 1. The requested block becomes E for a read or M for a write, held by the requester.
- R3: While the region is private, a read or write by the private owner produces kind NONE with mask 0 and leaves the entry unchanged.
- R4: A read or write by any other node to a private region first yields kind RVK with a one-hot mask naming the owner. The unblock bitmap lists the blocks the owner holds; each listed block becomes M held by the former owner, each unlisted block becomes invalid, and the region stops being private. The stored request is then decided again and a second probe beat follows.
- R5: A read to a block in E or M held by another node yields kind FWD, one-hot on that holder. On completion the block becomes S with the same holder, and the requester's region-vector bit is set.
- R6: A read by a non-holder to an S block yields kind NONE with mask 0. It sets only the requester's region-vector bit; the block's holder stays the same. A read to an invalid block in a shared region fills it as E for the requester, with no probe.
- R7: A write to an S block yields kind INV whose mask is the block holder OR the region vector, with the requester's bit removed. A write to an E or M block of another node invalidates just that holder. A write by the E/M holder itself upgrades the block to M with no probe.
- R8: On write completion, the requester becomes the block's holder in state M. Region-vector bits are cleared only for probed nodes whose bit in the unblock report is 0; every other bit stays.
- R9: An evict of a valid entry yields kind INV with mask equal to the region vector OR every valid block's holder. That is one probe per node, not per block. After completion the entry is empty. An evict of an empty entry yields kind NONE.
- R10: A read or write whose tag differs from a valid entry's tag yields kind MISS with mask 0 and changes nothing.
- R11: Only one request is in flight. req_ready is 0 from acceptance until the unblock is taken. A probe beat stays unchanged until probe_ready. A request or unblock offered while the entry is not waiting for it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Entry idle and accepting a request |
| req_op | input | 2 | 0 read, 1 write, 2 evict |
| req_node | input | 4 | Requesting node |
| req_blk | input | 4 | Block index within the region |
| req_tag | input | 22 | Region tag |
| probe_valid | output | 1 | Probe beat present |
| probe_ready | input | 1 | Probe beat taken |
| probe_mask | output | 16 | Target nodes |
| probe_kind | output | 3 | NONE/FWD/INV/RVK/MISS |
| probe_grant | output | 1 | Region granted private to requester |
| unblk_valid | input | 1 | Completion message |
| unblk_info | input | 16 | Keep-report per node (writes) or held-block bitmap (revoke) |

## Verification
Incorrect internal state in this entry shows up only through the target mask of a later probe. A stale or missing region-vector bit, for example, stays invisible until a write to a shared block or an evict. In this bench, that happens within a request or two. The reference model compares every output on every cycle, so a wrong holder pointer or block state shows at the next forward, invalidate or revoke decision. The scenarios chain allocation, revocation, sharing, upgrades, vector cleanup and eviction. Each step therefore exposes the state the previous step left behind.

// File: rtl/dgd_pkg.sv
package dgd_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_FWD  = 3'd1,
        K_INV  = 3'd2,
        K_RVK  = 3'd3,
        K_MISS = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        B_I = 2'd0,
        B_S = 2'd1,
        B_E = 2'd2,
        B_M = 2'd3
    } bst_e;

    typedef enum logic [3:0] {
        A_NOP, A_MISS, A_ALLOC, A_REVOKE, A_FILL,
        A_FWD, A_SHARE, A_UPG, A_WINV, A_EVICT
    } act_e;

    typedef enum logic [1:0] {
        P_IDLE  = 2'd0,
        P_PROBE = 2'd1,
        P_WAIT  = 2'd2
    } phase_e;

endpackage

// File: rtl/dgd_holders.sv
module dgd_holders #(
    parameter int NODES  = 16,
    parameter int BLOCKS = 16,
    localparam int NID_W = $clog2(NODES)
) (
    input  logic [BLOCKS-1:0]            blk_vld,
    input  logic [BLOCKS-1:0][NID_W-1:0] blk_id,
    output logic [NODES-1:0]             holders
);
    logic [BLOCKS-1:0][NODES-1:0] term;

    for (genvar g = 0; g < BLOCKS; g++) begin : g_term
        assign term[g] = blk_vld[g] ? (NODES'(1) << blk_id[g]) : '0;
    end

    always_comb begin
        holders = '0;
        for (int b = 0; b < BLOCKS; b++) begin
            holders = holders | term[b];
        end
    end
endmodule

// File: rtl/dgd_decide.sv
module dgd_decide
    import dgd_pkg::*;
#(
    parameter int NODES  = 16,
    parameter int BLOCKS = 16,
    parameter int TAG_W  = 22,
    localparam int NID_W = $clog2(NODES),
    localparam int BIX_W = $clog2(BLOCKS)
) (
    input  logic                         ent_vld,
    input  logic [TAG_W-1:0]             ent_tag,
    input  logic                         reg_priv,
    input  logic [NID_W-1:0]             reg_owner,
    input  logic [NODES-1:0]             vec,
    input  logic [BLOCKS-1:0]            blk_vld,
    input  logic [BLOCKS-1:0][1:0]       blk_st,
    input  logic [BLOCKS-1:0][NID_W-1:0] blk_id,
    input  logic [NODES-1:0]             holders,
    input  op_e                          op,
    input  logic [NID_W-1:0]             node,
    input  logic [BIX_W-1:0]             blk,
    input  logic [TAG_W-1:0]             tag,
    output act_e                         act,
    output kind_e                        kind,
    output logic [NODES-1:0]             mask,
    output logic                         grant
);
    logic [NODES-1:0] req_oh;
    logic [NODES-1:0] hold_oh;
    logic [NID_W-1:0] h;
    bst_e             st;

    always_comb begin
        req_oh  = NODES'(1) << node;
        h       = blk_id[blk];
        st      = bst_e'(blk_st[blk]);
        hold_oh = NODES'(1) << h;
        act     = A_NOP;
        kind    = K_NONE;
        mask    = '0;
        grant   = 1'b0;
        if (op == OP_EVICT) begin
            if (ent_vld) begin
                act  = A_EVICT;
                kind = K_INV;
                mask = vec | holders;
            end
        end else if (op == OP_READ || op == OP_WRITE) begin
            if (!ent_vld) begin
                act   = A_ALLOC;
                grant = 1'b1;
            end else if (tag != ent_tag) begin
                act  = A_MISS;
                kind = K_MISS;
            end else if (reg_priv) begin
                if (reg_owner != node) begin
                    act  = A_REVOKE;
                    kind = K_RVK;
                    mask = NODES'(1) << reg_owner;
                end
            end else if (!blk_vld[blk] || st == B_I) begin
                act = A_FILL;
            end else if (op == OP_READ) begin
                if (h != node) begin
                    if (st == B_S) begin
                        act = A_SHARE;
                    end else begin
                        act  = A_FWD;
                        kind = K_FWD;
                        mask = hold_oh;
                    end
                end
            end else begin
                if (st == B_S) begin
                    act  = A_WINV;
                    kind = K_INV;
                    mask = (hold_oh | vec) & ~req_oh;
                end else if (h == node) begin
                    act = A_UPG;
                end else begin
                    act  = A_WINV;
                    kind = K_INV;
                    mask = hold_oh;
                end
            end
        end
    end
endmodule

// File: rtl/dgd_entry.sv
module dgd_entry
    import dgd_pkg::*;
#(
    parameter int NODES  = 16,
    parameter int BLOCKS = 16,
    parameter int TAG_W  = 22,
    localparam int NID_W  = $clog2(NODES),
    localparam int BIX_W  = $clog2(BLOCKS),
    localparam int INFO_W = (NODES > BLOCKS) ? NODES : BLOCKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [NID_W-1:0]  req_node,
    input  logic [BIX_W-1:0]  req_blk,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              probe_valid,
    input  logic              probe_ready,
    output logic [NODES-1:0]  probe_mask,
    output logic [2:0]        probe_kind,
    output logic              probe_grant,
    input  logic              unblk_valid,
    input  logic [INFO_W-1:0] unblk_info
);
    typedef struct packed {
        phase_e                      ph;
        op_e                         op;
        logic [NID_W-1:0]            node;
        logic [BIX_W-1:0]            blk;
        logic [TAG_W-1:0]            tag;
        logic                        ent_vld;
        logic [TAG_W-1:0]            ent_tag;
        logic                        priv;
        logic [NID_W-1:0]            owner;
        logic [NODES-1:0]            vec;
        logic [BLOCKS-1:0]           bvld;
        logic [BLOCKS-1:0][1:0]      bst;
        logic [BLOCKS-1:0][NID_W-1:0] bid;
    } ent_t;

    ent_t q, d;

    logic [NODES-1:0] holders;
    act_e             act;
    kind_e            kind;
    logic [NODES-1:0] mask;
    logic             grant;

    dgd_holders #(.NODES(NODES), .BLOCKS(BLOCKS)) holders_i (
        .blk_vld (q.bvld),
        .blk_id  (q.bid),
        .holders (holders)
    );

    dgd_decide #(.NODES(NODES), .BLOCKS(BLOCKS), .TAG_W(TAG_W)) decide_i (
        .ent_vld   (q.ent_vld),
        .ent_tag   (q.ent_tag),
        .reg_priv  (q.priv),
        .reg_owner (q.owner),
        .vec       (q.vec),
        .blk_vld   (q.bvld),
        .blk_st    (q.bst),
        .blk_id    (q.bid),
        .holders   (holders),
        .op        (q.op),
        .node      (q.node),
        .blk       (q.blk),
        .tag       (q.tag),
        .act       (act),
        .kind      (kind),
        .mask      (mask),
        .grant     (grant)
    );

    assign req_ready   = (q.ph == P_IDLE);
    assign probe_valid = (q.ph == P_PROBE);
    assign probe_mask  = probe_valid ? mask : '0;
    assign probe_kind  = probe_valid ? kind : K_NONE;
    assign probe_grant = probe_valid && grant;

    always_comb begin
        d = q;
        unique case (q.ph)
            P_IDLE: begin
                if (req_valid) begin
                    d.op   = op_e'(req_op);
                    d.node = req_node;
                    d.blk  = req_blk;
                    d.tag  = req_tag;
                    d.ph   = P_PROBE;
                end
            end
            P_PROBE: begin
                if (probe_ready) d.ph = P_WAIT;
            end
            P_WAIT: begin
                if (unblk_valid) begin
                    d.ph = (act == A_REVOKE) ? P_PROBE : P_IDLE;
                    unique case (act)
                        A_ALLOC: begin
                            d.ent_vld      = 1'b1;
                            d.ent_tag      = q.tag;
                            d.priv         = 1'b1;
                            d.owner        = q.node;
                            d.vec          = '0;
                            d.bvld         = '0;
                            d.bst          = '0;
                            d.bvld[q.blk]  = 1'b1;
                            d.bst[q.blk]   = (q.op == OP_WRITE) ? B_M : B_E;
                            d.bid[q.blk]   = q.node;
                        end
                        A_REVOKE: begin
                            d.priv = 1'b0;
                            for (int b = 0; b < BLOCKS; b++) begin
                                d.bvld[b] = unblk_info[b];
                                d.bst[b]  = unblk_info[b] ? B_M : B_I;
                                d.bid[b]  = q.owner;
                            end
                        end
                        A_FILL: begin
                            d.bvld[q.blk] = 1'b1;
                            d.bst[q.blk]  = (q.op == OP_WRITE) ? B_M : B_E;
                            d.bid[q.blk]  = q.node;
                        end
                        A_FWD: begin
                            d.bst[q.blk]  = B_S;
                            d.vec[q.node] = 1'b1;
                        end
                        A_SHARE: d.vec[q.node] = 1'b1;
                        A_UPG:   d.bst[q.blk]  = B_M;
                        A_WINV: begin
                            d.bid[q.blk] = q.node;
                            d.bst[q.blk] = B_M;
                            d.vec        = q.vec & ~(mask & ~unblk_info[NODES-1:0]);
                        end
                        A_EVICT: begin
                            d.ent_vld = 1'b0;
                            d.priv    = 1'b0;
                            d.vec     = '0;
                            d.bvld    = '0;
                            d.bst     = '0;
                        end
                        default: ;
                    endcase
                end
            end
            default: d.ph = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R11: an accepted request makes the entry busy and presents a beat next cycle
    a_r11_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && probe_valid);

    // R11: a pending probe beat holds its content until taken
    a_r11_probe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid && !probe_ready |=> probe_valid && $stable(probe_mask)
                                        && $stable(probe_kind) && $stable(probe_grant));

    // R7: a write never probes its own requester
    a_r7_no_self_inv: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid && probe_kind == K_INV && q.op == OP_WRITE |-> !probe_mask[q.node]);

    // R5 and R4: forwards and revocations target exactly one node
    a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid && (probe_kind == K_FWD || probe_kind == K_RVK)
        |-> $countones(probe_mask) == 1);

    // R8: write completion can only remove region-vector bits
    a_r8_vec_no_gain: assert property (@(posedge clk) disable iff (!rst_n)
        q.ph == P_WAIT && unblk_valid && act == A_WINV
        |=> (q.vec & ~$past(q.vec)) == '0);

    // R2: a private grant is only issued on an empty entry with no sharers
    a_r2_grant_empty: assert property (@(posedge clk) disable iff (!rst_n)
        probe_grant |-> !q.ent_vld && q.vec == '0 && probe_mask == '0);

    // R10: a tag miss never carries targets
    a_r10_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid && probe_kind == K_MISS |-> probe_mask == '0);

endmodule

// File: tb/dgd_entry_tb.sv
module dgd_entry_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [3:0]  req_node = '0;
    logic [3:0]  req_blk = '0;
    logic [21:0] req_tag = '0;
    logic        probe_valid;
    logic        probe_ready = 1'b0;
    logic [15:0] probe_mask;
    logic [2:0]  probe_kind;
    logic        probe_grant;
    logic        unblk_valid = 1'b0;
    logic [15:0] unblk_info = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dgd_entry dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_node(req_node), .req_blk(req_blk), .req_tag(req_tag),
        .probe_valid(probe_valid), .probe_ready(probe_ready),
        .probe_mask(probe_mask), .probe_kind(probe_kind), .probe_grant(probe_grant),
        .unblk_valid(unblk_valid), .unblk_info(unblk_info)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    finished = 1'b0;
    string cur_lbl = "R1";

    // reference model state
    int         m_ph;          // 0 idle, 1 probe, 2 wait
    int         m_op, m_node, m_blk, m_tag;
    bit         m_vld, m_priv;
    int         m_etag, m_owner;
    bit [15:0]  m_vec;
    bit         m_bvld[16];
    int         m_bst[16];
    int         m_bid[16];

    // act codes: 0 nop 1 miss 2 alloc 3 revoke 4 fill 5 fwd 6 share 7 upg 8 winv 9 evict
    task automatic m_decide(output int act, output int kind, output bit [15:0] mask,
                            output bit grant);
        bit [15:0] hold;
        act = 0; kind = 0; mask = '0; grant = 0;
        hold = '0;
        for (int b = 0; b < 16; b++) if (m_bvld[b]) hold[m_bid[b]] = 1'b1;
        if (m_op == 2) begin
            if (m_vld) begin act = 9; kind = 2; mask = m_vec | hold; end
        end else if (m_op < 2) begin
            if (!m_vld) begin act = 2; grant = 1; end
            else if (m_tag != m_etag) begin act = 1; kind = 4; end
            else if (m_priv) begin
                if (m_owner != m_node) begin act = 3; kind = 3; mask[m_owner] = 1'b1; end
            end else if (!m_bvld[m_blk] || m_bst[m_blk] == 0) act = 4;
            else if (m_op == 0) begin
                if (m_bid[m_blk] != m_node) begin
                    if (m_bst[m_blk] == 1) act = 6;
                    else begin act = 5; kind = 1; mask[m_bid[m_blk]] = 1'b1; end
                end
            end else begin
                if (m_bst[m_blk] == 1) begin
                    act = 8; kind = 2; mask = m_vec; mask[m_bid[m_blk]] = 1'b1;
                    mask[m_node] = 1'b0;
                end else if (m_bid[m_blk] == m_node) act = 7;
                else begin act = 8; kind = 2; mask[m_bid[m_blk]] = 1'b1; end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_vld = 0; m_priv = 0; m_vec = '0;
            for (int b = 0; b < 16; b++) begin m_bvld[b] = 0; m_bst[b] = 0; m_bid[b] = 0; end
        end else begin
            int act, kind; bit [15:0] mask; bit grant;
            m_decide(act, kind, mask, grant);
            if (m_ph == 0) begin
                if (req_valid) begin
                    m_op = req_op; m_node = req_node; m_blk = req_blk; m_tag = req_tag; m_ph = 1;
                end
            end else if (m_ph == 1) begin
                if (probe_ready) m_ph = 2;
            end else if (unblk_valid) begin
                m_ph = (act == 3) ? 1 : 0;
                case (act)
                    2: begin
                        m_vld = 1; m_etag = m_tag; m_priv = 1; m_owner = m_node; m_vec = '0;
                        for (int b = 0; b < 16; b++) begin m_bvld[b] = 0; m_bst[b] = 0; end
                        m_bvld[m_blk] = 1; m_bst[m_blk] = (m_op == 1) ? 3 : 2; m_bid[m_blk] = m_node;
                    end
                    3: begin
                        m_priv = 0;
                        for (int b = 0; b < 16; b++) begin
                            m_bvld[b] = unblk_info[b]; m_bst[b] = unblk_info[b] ? 3 : 0;
                            m_bid[b] = m_owner;
                        end
                    end
                    4: begin m_bvld[m_blk] = 1; m_bst[m_blk] = (m_op == 1) ? 3 : 2; m_bid[m_blk] = m_node; end
                    5: begin m_bst[m_blk] = 1; m_vec[m_node] = 1; end
                    6: m_vec[m_node] = 1;
                    7: m_bst[m_blk] = 3;
                    8: begin m_bid[m_blk] = m_node; m_bst[m_blk] = 3; m_vec = m_vec & ~(mask & ~unblk_info); end
                    9: begin
                        m_vld = 0; m_priv = 0; m_vec = '0;
                        for (int b = 0; b < 16; b++) begin m_bvld[b] = 0; m_bst[b] = 0; end
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string what, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_lbl, what, act_v, exp_v);
        end
    endtask

    // compare every output against the model on each falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int act, kind; bit [15:0] mask; bit grant;
            m_decide(act, kind, mask, grant);
            check(req_ready == (m_ph == 0), "req_ready", req_ready, m_ph == 0);
            check(probe_valid == (m_ph == 1), "probe_valid", probe_valid, m_ph == 1);
            if (m_ph == 1) begin
                check(probe_mask == mask, "probe_mask", probe_mask, mask);
                check(int'(probe_kind) == kind, "probe_kind", probe_kind, kind);
                check(probe_grant == grant, "probe_grant", probe_grant, grant);
            end
        end
    end

    // direct spot check on a beat against a hand-worked value
    task automatic expect_beat(input int kind, input bit [15:0] mask, input bit grant);
        check(int'(probe_kind) == kind, "beat kind", probe_kind, kind);
        check(probe_mask == mask, "beat mask", probe_mask, mask);
        check(probe_grant == grant, "beat grant", probe_grant, grant);
    endtask

    task automatic do_op(input int op, input int node, input int blk, input int tag,
                         input bit [15:0] rvk_info, input bit [15:0] fin_info,
                         input int stall, input string lbl,
                         input int ek, input bit [15:0] em, input bit eg);
        bit done = 0;
        bit first = 1;
        cur_lbl = lbl;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_op = op[1:0]; req_node = node[3:0]; req_blk = blk[3:0]; req_tag = tag[21:0];
        @(negedge clk);
        req_valid = 0;
        while (!done) begin
            int k;
            while (!probe_valid) @(negedge clk);
            for (int s = 0; s < stall; s++) begin
                req_valid = (s == 0);   // R11: offered while busy, must be ignored
                req_op = 2'd2; req_node = 4'd15;
                @(negedge clk);
                req_valid = 0;
            end
            k = probe_kind;
            if (k != 3 && !first) expect_beat(ek, em, eg);
            else if (first && k != 3) expect_beat(ek, em, eg);
            first = 0;
            probe_ready = 1;
            @(negedge clk);
            probe_ready = 0;
            unblk_valid = 1;
            unblk_info = (k == 3) ? rvk_info : fin_info;
            @(negedge clk);
            unblk_valid = 0;
            if (k != 3) done = 1;
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    localparam int TA = 22'h1234;
    localparam int TB = 22'h0777;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_lbl = "R1";
        check(req_ready == 1'b1, "reset ready", req_ready, 1);
        check(probe_valid == 1'b0, "reset probe", probe_valid, 0);
        // R2 allocation by node 2, read block 3
        do_op(0, 2, 3, TA, 16'h0, 16'h0, 0, "R2", 0, 16'h0000, 1);
        // R3 owner write in its private region
        do_op(1, 2, 5, TA, 16'h0, 16'h0, 0, "R3", 0, 16'h0000, 0);
        // R4 revoke: owner holds blocks 3 and 5, then R5 forward to node 2
        do_op(0, 7, 5, TA, 16'h0028, 16'h0, 0, "R4", 1, 16'h0004, 0);
        // R6 read of shared block by a non-holder
        do_op(0, 9, 5, TA, 16'h0, 16'h0, 0, "R6", 0, 16'h0000, 0);
        // R5 forward of block 3 from node 2 to node 4, with a stalled probe (R11)
        do_op(0, 4, 3, TA, 16'h0, 16'h0, 3, "R5", 1, 16'h0004, 0);
        // R11 stray unblock while idle
        cur_lbl = "R11";
        @(negedge clk); unblk_valid = 1; unblk_info = 16'hffff;
        @(negedge clk); unblk_valid = 0;
        // R7 write to shared block 5 by node 9: holder 2 plus vector {4,7,9} minus 9
        // R8 report keeps 2 and 4, drops 7
        do_op(1, 9, 5, TA, 16'h0, 16'h0014, 0, "R7", 2, 16'h0094, 0);
        // R10 tag mismatch
        do_op(0, 1, 0, TB, 16'h0, 16'h0, 0, "R10", 4, 16'h0000, 0);
        // R8 write by node 4 to block 3: vector now {4,9}, targets {2,9}
        do_op(1, 4, 3, TA, 16'h0, 16'h0200, 2, "R8", 2, 16'h0204, 0);
        // R9 evict: vector {4,9} plus holders {4,9}
        do_op(2, 0, 0, 0, 16'h0, 16'h0, 0, "R9", 2, 16'h0210, 0);
        // R9 evict of an empty entry
        do_op(2, 0, 0, 0, 16'h0, 16'h0, 0, "R9", 0, 16'h0000, 0);
        // R1 empty again: allocation by node 5 write
        do_op(1, 5, 0, TB, 16'h0, 16'h0, 0, "R1", 0, 16'h0000, 1);
        // R4 revoke with nothing held, then fill for node 6
        do_op(1, 6, 0, TB, 16'h0000, 16'h0, 0, "R4", 0, 16'h0000, 0);
        // R6 fill by read, R7 upgrade by holder, R5 forward to holder 6
        do_op(0, 6, 1, TB, 16'h0, 16'h0, 0, "R6", 0, 16'h0000, 0);
        do_op(1, 6, 1, TB, 16'h0, 16'h0, 0, "R7", 0, 16'h0000, 0);
        do_op(0, 3, 1, TB, 16'h0, 16'h0, 1, "R5", 1, 16'h0040, 0);
        // R7 write to E/M block of another node: block 0 M held by 6
        do_op(1, 3, 0, TB, 16'h0, 16'h0, 0, "R7", 2, 16'h0040, 0);
        // R9 final eviction: vector {3}, holders {3 (blk0), 6 (blk1)}
        do_op(2, 0, 0, 0, 16'h0, 16'h0, 0, "R9", 2, 16'h0048, 0);
        repeat (3) @(negedge clk);
        summary();
    end
endmodule